// File: doc/BRIEF.md
# Boundary Scan Register Chain

This block is the serial boundary scan data register of a device. It is a string of one-bit cells between the test data input and the test data output. Most cells are combined bidirectional pin cells. Each one serves a single pad, which is modelled as separate input, output and active-low output-enable signals. Control cells are placed between the pin cells. Each control cell holds the active-low output enable for the pin cells that follow it, up to the next control cell. The block is clocked by the test clock. A separate test access port controller drives it with capture, shift and update strobes and two decoded instruction selects: one for sampling or preloading, one for external test.

While the sample/preload select is active, a capture takes a snapshot of the live enables, outputs and pad inputs. The shift path then loads new data without disturbing the pads. An update copies the shift stages into a second rank of latches. While the external-test select is active, the pads are driven from those latches and capture reads back the pins. The chain length and the control-cell placement are parameters. By default the chain is 173 cells long, and a control cell sits at every ninth position counting from the input end. The test-port pins themselves have no cells.

Top module: `bscan_chain`

## Requirements
- R1: Cell 0 takes `tdi`, each later cell shifts from the one before it, and `tdo` shows the last cell. A pattern loaded by CHAIN_LEN shifts (173 by default) comes out unchanged after exactly CHAIN_LEN further shifts.
- R2: Bit i of CTRL_MASK set makes cell i a control cell. The default sets cells 0, 9, 18, ..., 171. Each pin cell is governed by the nearest control cell on its `tdi` side. Pin cells are numbered upward from the `tdi` end, skipping control cells, and control cells are numbered the same way. Pin cells with no control cell before them are input only.
- R3: A capture under sample/preload loads each control cell with its group's `core_oe_n` bit. Each pin cell captures `core_out` when its group's enable is 0, and `pad_in` otherwise.
- R4: While `sel_extest` is 0, `pad_out` equals `core_out` and `pad_oe_n` equals the governing group's `core_oe_n`. This holds whatever is shifted or updated.
- R5: The update latches copy the shift stages only on an `update_dr` strobe while an instruction is selected. Shifting alone never changes them.
- R6: While `sel_extest` is 1, each `pad_out` comes from its pin cell's update latch. Each `pad_oe_n` comes from its governing control cell's update latch (0 = drive).
- R7: A capture under external test loads each control cell with its own update latch. Each pin cell captures its update latch when its governing latch is 0, and `pad_in` otherwise.
- R8: `trst_n` low clears all shift stages and pin update latches to 0 and sets all control update latches to 1 (outputs disabled).
- R9: When neither select is active, the capture, shift and update strobes leave all shift stages and update latches unchanged. The two selects are never active together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| tck | input | 1 | Test clock |
| trst_n | input | 1 | Asynchronous test reset, active low |
| tdi | input | 1 | Serial data into cell 0 |
| tdo | output | 1 | Serial data from the last cell |
| capture_dr | input | 1 | Capture strobe for one clock |
| shift_dr | input | 1 | Shift enable |
| update_dr | input | 1 | Update strobe for one clock |
| sel_sample | input | 1 | Sample/preload instruction selected |
| sel_extest | input | 1 | External test instruction selected |
| core_out | input | NUM_PINS | Core output value per pin |
| core_oe_n | input | NUM_CTRL | Core output enable per control group, active low |
| pad_in | input | NUM_PINS | Value seen at each pad |
| pad_out | output | NUM_PINS | Value driven to each pad |
| pad_oe_n | output | NUM_PINS | Pad output enable, active low |

## Verification
The hardest case to reach is an external-test capture in which a pin cell's result depends on the update latch of a different cell, its control cell. Reaching it takes a full-length preload under sample/preload, an update, a switch of instruction, a change of pad inputs, and then a capture and a full unload. The bench runs that sequence. It uses a preload in which even groups drive and odd groups float, so both branches of the capture choice appear within one unload. A separate step shifts without updating and strobes with no instruction selected, then reads the pads and the unloaded chain to show that nothing moved.

// File: rtl/bscan_pkg.sv
package bscan_pkg;

   localparam int MAX_CELLS = 256;

   typedef logic [MAX_CELLS-1:0] cell_mask_t;

   // Mask with a control cell at every STRIDE-th position below LEN
   function automatic cell_mask_t stride_mask(input int len, input int stride);
      cell_mask_t m;
      m = '0;
      for (int j = 0; j < MAX_CELLS; j++) begin
         if (j < len && (j % stride) == 0) m[j] = 1'b1;
      end
      return m;
   endfunction

   // Number of control cells strictly below position idx
   function automatic int ctrl_before(input cell_mask_t m, input int idx);
      int n;
      n = 0;
      for (int j = 0; j < MAX_CELLS; j++) begin
         if (j < idx && m[j]) n++;
      end
      return n;
   endfunction

endpackage

// File: rtl/bscan_ctrl_cell.sv
module bscan_ctrl_cell (
   input  logic clk,
   input  logic rst_n,
   input  logic cap_en,
   input  logic sh_en,
   input  logic upd_en,
   input  logic extest,
   input  logic ser_in,
   input  logic core_oe_n,
   output logic ser_out,
   output logic lat_oe_n
);

   logic sr_q;
   logic upd_q;
   logic cap_val;

   // Captured value is the enable presently in force
   always_comb begin
      cap_val = extest ? upd_q : core_oe_n;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      sr_q <= 1'b0;
      else if (cap_en) sr_q <= cap_val;
      else if (sh_en)  sr_q <= ser_in;
   end

   // Reset leaves the group disabled
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      upd_q <= 1'b1;
      else if (upd_en) upd_q <= sr_q;
   end

   assign ser_out  = sr_q;
   assign lat_oe_n = upd_q;

   AST_CTRL_SHIFT_MOVES: assert property (@(posedge clk) disable iff (!rst_n)
      sh_en && !cap_en |=> sr_q == $past(ser_in)); // R1
   AST_CTRL_UPD_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
      !upd_en |=> $stable(upd_q)); // R5
   AST_CTRL_IDLE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
      !(sh_en || cap_en) |=> $stable(sr_q)); // R9

endmodule

// File: rtl/bscan_pin_cell.sv
module bscan_pin_cell (
   input  logic clk,
   input  logic rst_n,
   input  logic cap_en,
   input  logic sh_en,
   input  logic upd_en,
   input  logic extest,
   input  logic ser_in,
   input  logic core_out,
   input  logic grp_core_oe_n,
   input  logic grp_lat_oe_n,
   input  logic pad_in,
   output logic ser_out,
   output logic pad_out,
   output logic pad_oe_n
);

   logic sr_q;
   logic upd_q;
   logic drive_val;
   logic eff_oe_n;
   logic cap_val;

   always_comb begin
      eff_oe_n  = extest ? grp_lat_oe_n : grp_core_oe_n;
      drive_val = extest ? upd_q : core_out;
      // Driving: read back the outgoing value; floating: read the pad
      cap_val   = eff_oe_n ? pad_in : drive_val;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      sr_q <= 1'b0;
      else if (cap_en) sr_q <= cap_val;
      else if (sh_en)  sr_q <= ser_in;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      upd_q <= 1'b0;
      else if (upd_en) upd_q <= sr_q;
   end

   assign ser_out  = sr_q;
   assign pad_out  = drive_val;
   assign pad_oe_n = eff_oe_n;

   AST_PIN_SHIFT_MOVES: assert property (@(posedge clk) disable iff (!rst_n)
      sh_en && !cap_en |=> sr_q == $past(ser_in)); // R1
   AST_PIN_UPD_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
      !upd_en |=> $stable(upd_q)); // R5
   AST_PIN_IDLE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
      !(sh_en || cap_en) |=> $stable(sr_q)); // R9

endmodule

// File: rtl/bscan_chain.sv
module bscan_chain #(
   parameter int                    CHAIN_LEN = 173,
   parameter bscan_pkg::cell_mask_t CTRL_MASK = bscan_pkg::stride_mask(CHAIN_LEN, 9),
   // Derived; leave at default
   parameter int                    NUM_CTRL  = bscan_pkg::ctrl_before(CTRL_MASK, CHAIN_LEN),
   parameter int                    NUM_PINS  = CHAIN_LEN - NUM_CTRL
) (
   input  logic                tck,
   input  logic                trst_n,
   input  logic                tdi,
   output logic                tdo,
   input  logic                capture_dr,
   input  logic                shift_dr,
   input  logic                update_dr,
   input  logic                sel_sample,
   input  logic                sel_extest,
   input  logic [NUM_PINS-1:0] core_out,
   input  logic [NUM_CTRL-1:0] core_oe_n,
   input  logic [NUM_PINS-1:0] pad_in,
   output logic [NUM_PINS-1:0] pad_out,
   output logic [NUM_PINS-1:0] pad_oe_n
);

   localparam int CTRL_SEEN = bscan_pkg::ctrl_before(CTRL_MASK, CHAIN_LEN);

   if (CHAIN_LEN < 2 || CHAIN_LEN > bscan_pkg::MAX_CELLS) begin : g_bad_len
      $error("CHAIN_LEN out of range");
   end
   if (NUM_CTRL != CTRL_SEEN || NUM_PINS != CHAIN_LEN - CTRL_SEEN) begin : g_bad_count
      $error("NUM_CTRL/NUM_PINS must not be overridden");
   end
   if (NUM_CTRL < 1 || NUM_PINS < 1) begin : g_bad_mix
      $error("chain needs at least one control and one pin cell");
   end

   logic                active;
   logic                cap_en;
   logic                sh_en;
   logic                upd_en;
   logic [CHAIN_LEN:0]  ser;
   logic [NUM_CTRL-1:0] grp_lat_oe_n;

   always_comb begin
      active = sel_sample | sel_extest;
      cap_en = active & capture_dr;
      sh_en  = active & shift_dr & ~capture_dr;
      upd_en = active & update_dr;
   end

   assign ser[0] = tdi;
   assign tdo    = ser[CHAIN_LEN];

   for (genvar i = 0; i < CHAIN_LEN; i++) begin : g_cell
      localparam int CBELOW = bscan_pkg::ctrl_before(CTRL_MASK, i);
      if (CTRL_MASK[i]) begin : g_ctrl
         bscan_ctrl_cell u_cell (
            .clk       (tck),
            .rst_n     (trst_n),
            .cap_en    (cap_en),
            .sh_en     (sh_en),
            .upd_en    (upd_en),
            .extest    (sel_extest),
            .ser_in    (ser[i]),
            .core_oe_n (core_oe_n[CBELOW]),
            .ser_out   (ser[i+1]),
            .lat_oe_n  (grp_lat_oe_n[CBELOW])
         );
      end else begin : g_pin
         localparam int PIDX = i - CBELOW;
         logic grp_core;
         logic grp_lat;
         if (CBELOW == 0) begin : g_free
            assign grp_core = 1'b1;
            assign grp_lat  = 1'b1;
         end else begin : g_owned
            assign grp_core = core_oe_n[CBELOW-1];
            assign grp_lat  = grp_lat_oe_n[CBELOW-1];
         end
         bscan_pin_cell u_cell (
            .clk           (tck),
            .rst_n         (trst_n),
            .cap_en        (cap_en),
            .sh_en         (sh_en),
            .upd_en        (upd_en),
            .extest        (sel_extest),
            .ser_in        (ser[i]),
            .core_out      (core_out[PIDX]),
            .grp_core_oe_n (grp_core),
            .grp_lat_oe_n  (grp_lat),
            .pad_in        (pad_in[PIDX]),
            .ser_out       (ser[i+1]),
            .pad_out       (pad_out[PIDX]),
            .pad_oe_n      (pad_oe_n[PIDX])
         );
      end
   end

   AST_ONE_INSTR: assert property (@(posedge tck) disable iff (!trst_n)
      !(sel_sample && sel_extest)); // R9
   AST_TDO_FOLLOWS_CHAIN: assert property (@(posedge tck) disable iff (!trst_n)
      sh_en |=> tdo == $past(ser[CHAIN_LEN-1])); // R1

endmodule

// File: tb/bscan_chain_tb.sv
module bscan_chain_tb_top;

   localparam int LEN = 173;
   localparam int NP  = 153;
   localparam int NC  = 20;

   logic          tck = 1'b0;
   logic          trst_n = 1'b0;
   logic          tdi = 1'b0;
   logic          tdo;
   logic          capture_dr = 1'b0;
   logic          shift_dr = 1'b0;
   logic          update_dr = 1'b0;
   logic          sel_sample = 1'b0;
   logic          sel_extest = 1'b0;
   logic [NP-1:0] core_out = '0;
   logic [NC-1:0] core_oe_n = '1;
   logic [NP-1:0] pad_in = '0;
   logic [NP-1:0] pad_out;
   logic [NP-1:0] pad_oe_n;

   int n_total = 0;
   int n_fail  = 0;

   logic [LEN-1:0] q_pre;
   logic [LEN-1:0] l_pat;

   always #10 tck = ~tck;

   bscan_chain dut_i (
      .tck(tck), .trst_n(trst_n), .tdi(tdi), .tdo(tdo),
      .capture_dr(capture_dr), .shift_dr(shift_dr), .update_dr(update_dr),
      .sel_sample(sel_sample), .sel_extest(sel_extest),
      .core_out(core_out), .core_oe_n(core_oe_n), .pad_in(pad_in),
      .pad_out(pad_out), .pad_oe_n(pad_oe_n)
   );

   // Bench's own view of the default layout (R2)
   function automatic bit is_ctrl(input int i); return (i % 9) == 0; endfunction
   function automatic int grp_of(input int i);  return i / 9;          endfunction
   function automatic int pin_of(input int i);  return i - i / 9 - 1;  endfunction

   function automatic logic [NP-1:0] expand_grp(input logic [NC-1:0] g);
      logic [NP-1:0] r;
      r = '0;
      for (int i = 0; i < LEN; i++) if (!is_ctrl(i)) r[pin_of(i)] = g[grp_of(i)];
      return r;
   endfunction

   function automatic logic [NP-1:0] pins_of_cells(input logic [LEN-1:0] c);
      logic [NP-1:0] r;
      r = '0;
      for (int i = 0; i < LEN; i++) if (!is_ctrl(i)) r[pin_of(i)] = c[i];
      return r;
   endfunction

   function automatic logic [NP-1:0] oe_of_cells(input logic [LEN-1:0] c);
      logic [NP-1:0] r;
      r = '0;
      for (int i = 0; i < LEN; i++) if (!is_ctrl(i)) r[pin_of(i)] = c[9 * grp_of(i)];
      return r;
   endfunction

   task automatic chk(input string req, input string what,
                      input logic [255:0] got, input logic [255:0] exp);
      n_total++;
      if (got !== exp) begin
         n_fail++;
         $display("FAIL %s %s: actual %h expected %h", req, what, got, exp);
      end
   endtask

   // Load cells with ld and return what the cells held before
   task automatic scan(input logic [LEN-1:0] ld, output logic [LEN-1:0] got);
      got = '0;
      for (int k = 0; k < LEN; k++) begin
         @(negedge tck);
         shift_dr = 1'b1;
         tdi = ld[LEN-1-k];
         got[LEN-1-k] = tdo;
      end
      @(negedge tck);
      shift_dr = 1'b0;
   endtask

   task automatic pulse_capture;
      @(negedge tck) capture_dr = 1'b1;
      @(negedge tck) capture_dr = 1'b0;
   endtask

   task automatic pulse_update;
      @(negedge tck) update_dr = 1'b1;
      @(negedge tck) update_dr = 1'b0;
   endtask

   task automatic set_instr(input logic s, input logic x);
      @(negedge tck);
      sel_sample = s;
      sel_extest = x;
      #1;
   endtask

   task automatic t_reset;
      logic [LEN-1:0] got;
      set_instr(1'b0, 1'b1);
      chk("R8", "control latches after reset", {103'b0, pad_oe_n}, {103'b0, {NP{1'b1}}});
      chk("R8", "pin latches after reset", {103'b0, pad_out}, 256'b0);
      scan('0, got);
      chk("R8", "shift stages after reset", {83'b0, got}, 256'b0);
      set_instr(1'b0, 1'b0);
   endtask

   task automatic t_length;
      logic [LEN-1:0] p;
      logic [LEN-1:0] got;
      for (int i = 0; i < LEN; i++) p[i] = ((i * 7 + 3) % 5) < 2;
      set_instr(1'b1, 1'b0);
      scan(p, got);
      scan('0, got);
      chk("R1", "pattern after exactly 173 shifts", {83'b0, got}, {83'b0, p});
   endtask

   task automatic t_passthru;
      set_instr(1'b0, 1'b0);
      for (int p = 0; p < NP; p++) core_out[p] = (p % 5) == 2;
      for (int g = 0; g < NC; g++) core_oe_n[g] = (g % 2) == 1;
      #1;
      chk("R4", "pad_out follows core", {103'b0, pad_out}, {103'b0, core_out});
      chk("R4", "pad_oe_n follows group", {103'b0, pad_oe_n}, {103'b0, expand_grp(core_oe_n)});
   endtask

   task automatic t_sample_capture;
      logic [LEN-1:0] exp;
      logic [LEN-1:0] got;
      for (int p = 0; p < NP; p++) begin
         core_out[p] = p % 2;
         pad_in[p]   = (p % 3) == 0;
      end
      for (int g = 0; g < NC; g++) core_oe_n[g] = (g % 3) == 0;
      set_instr(1'b1, 1'b0);
      for (int i = 0; i < LEN; i++) begin
         if (is_ctrl(i)) exp[i] = core_oe_n[grp_of(i)];
         else exp[i] = core_oe_n[grp_of(i)] ? pad_in[pin_of(i)] : core_out[pin_of(i)];
      end
      pulse_capture();
      scan('0, got);
      chk("R3", "sample capture (R2 layout)", {83'b0, got}, {83'b0, exp});
   endtask

   task automatic t_update;
      logic [LEN-1:0] got;
      for (int i = 0; i < LEN; i++) begin
         if (is_ctrl(i)) q_pre[i] = (grp_of(i) % 2) == 1;
         else q_pre[i] = ((i * 5) % 7) < 3;
      end
      set_instr(1'b1, 1'b0);
      scan(q_pre, got);
      set_instr(1'b0, 1'b1);
      chk("R5", "shift alone leaves pin latches", {103'b0, pad_out}, 256'b0);
      chk("R5", "shift alone leaves control latches", {103'b0, pad_oe_n}, {103'b0, {NP{1'b1}}});
      set_instr(1'b1, 1'b0);
      pulse_update();
      #1;
      chk("R4", "sample update keeps pad_out on core", {103'b0, pad_out}, {103'b0, core_out});
      chk("R4", "sample update keeps pad_oe_n on core", {103'b0, pad_oe_n}, {103'b0, expand_grp(core_oe_n)});
      set_instr(1'b0, 1'b1);
      chk("R6", "extest pad_out from latches", {103'b0, pad_out}, {103'b0, pins_of_cells(q_pre)});
      chk("R6", "extest pad_oe_n from control latches (R2)", {103'b0, pad_oe_n}, {103'b0, oe_of_cells(q_pre)});
   endtask

   task automatic t_extest_capture;
      logic [LEN-1:0] exp;
      logic [LEN-1:0] got;
      for (int p = 0; p < NP; p++) pad_in[p] = (p % 4) == 1;
      for (int i = 0; i < LEN; i++) begin
         l_pat[i] = i % 2;
         if (is_ctrl(i)) exp[i] = q_pre[i];
         else exp[i] = q_pre[9 * grp_of(i)] ? pad_in[pin_of(i)] : q_pre[i];
      end
      set_instr(1'b0, 1'b1);
      pulse_capture();
      scan(l_pat, got);
      chk("R7", "extest capture", {83'b0, got}, {83'b0, exp});
   endtask

   task automatic t_idle;
      logic [LEN-1:0] got;
      set_instr(1'b0, 1'b0);
      pulse_capture();
      scan('1, got);
      pulse_update();
      set_instr(1'b0, 1'b1);
      chk("R9", "idle strobes keep pin latches", {103'b0, pad_out}, {103'b0, pins_of_cells(q_pre)});
      chk("R9", "idle strobes keep control latches", {103'b0, pad_oe_n}, {103'b0, oe_of_cells(q_pre)});
      set_instr(1'b1, 1'b0);
      scan('0, got);
      chk("R9", "idle strobes keep shift stages", {83'b0, got}, {83'b0, l_pat});
   endtask

   initial begin
      repeat (3) @(negedge tck);
      trst_n = 1'b1;
      t_reset();
      t_length();
      t_passthru();
      t_sample_capture();
      t_update();
      t_extest_capture();
      t_idle();
      $display("%0d/%0d checks passed", n_total - n_fail, n_total);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge tck);
      n_total++;
      n_fail++;
      $display("FAIL watchdog: actual running expected done");
      $display("%0d/%0d checks passed", n_total - n_fail, n_total);
      $finish;
   end

endmodule